// File: doc/BRIEF.md
# Round-Robin Interleaved Compute Array

This block gets a higher result rate out of a slow combinational function by building several copies of it, rather than by cutting the function into pipeline stages. `NUM_UNITS` identical units sit side by side. A modulo-`NUM_UNITS` slot counter advances on every clock. It picks the unit that captures the operand pair on the input this cycle, and the same counter picks the unit whose result is shown on the output.

Each unit keeps its operands for a whole lap of the counter, which is `NUM_UNITS` clocks. Its slow logic therefore has that many clock periods to settle. The result is read back when the counter returns to that unit's slot.

Taken together, the array accepts one operand pair per clock. Every result appears exactly `NUM_UNITS` clocks after its operands, so results leave in arrival order. The function computed is `result = A*B + (A XOR B)`, taken modulo 2^(2*DATA_W). There is no back-pressure: the producer may present a pair on every clock or leave gaps.

Top module: `interleave_array`

## Requirements
- R1: While reset is asserted, `outValid` is 0. After reset is released it stays 0 until the first captured operand pair comes round, and it starts counting from slot 0.
- R2: `outValid` in cycle t+NUM_UNITS equals `inValid` in cycle t, for every cycle.
- R3: Whenever `outValid` is 1, `outResult` equals `A*B + (A XOR B)` modulo 2^(2*DATA_W), computed from the `inA`/`inB` presented NUM_UNITS cycles earlier.
- R4: An operand pair is accepted on every clock with `inValid` high, back to back. Exactly one unit captures per cycle, so NUM_UNITS operations are in flight at full rate.
- R5: The slot counter advances even when `inValid` is 0. The unit skipped that cycle yields no valid result NUM_UNITS cycles later, and the results of its neighbours are unaffected.
- R6: A unit's operands stay unchanged for the whole NUM_UNITS cycles between its captures, even though other units capture fresh operands in every one of those cycles.
- R7: Results leave in exactly the order their operand pairs arrived, including across gaps in the input stream.
- R8: A reset asserted in the middle of a stream discards every operation in flight: after release, none of them reappears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on `inA`/`inB` is valid this cycle |
| inA | input | DATA_W | First operand |
| inB | input | DATA_W | Second operand |
| outValid | output | 1 | `outResult` holds a valid result this cycle |
| outResult | output | 2*DATA_W | Result of the unit owning the current slot |

## Verification
The assertions in the RTL check, on every cycle, the following:
- the slot counter steps by one and wraps at the last slot;
- exactly one unit captures per cycle;
- an idle unit's operands and flag do not move;
- `outValid` tracks a shadow record of `inValid` delayed by the unit count.

The bench shows the arithmetic value of every result, which only its scenarios can do. These scenarios are:
- full-rate random streams;
- extreme operands;
- random and periodic gaps that leave one slot permanently empty;
- increasing operands that make the output order visible;
- a reset in mid-stream whose in-flight results must never surface.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Width of the slot index carried in the strobe struct.
  localparam int SLOT_W = 4;
  localparam int MAX_UNITS = 1 << SLOT_W;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic              capture;  // operand pair on the input is valid
    logic [SLOT_W-1:0] slot;     // unit owning this cycle (capture and output)
  } ilvStrobe_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl #(
  parameter int NUM_UNITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output ilv_pkg::ilvStrobe_t strobe
);
  import ilv_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_UNITS - 1);

  logic [SLOT_W-1:0] slotQ;

  initial begin
    assert (NUM_UNITS >= 2 && NUM_UNITS <= MAX_UNITS)
      else $error("NUM_UNITS out of range");
  end

  // Free-running modulo-N slot counter; it never waits for inValid.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (slotQ == LAST_SLOT) begin
      slotQ <= '0;
    end else begin
      slotQ <= slotQ + 1'b1;
    end
  end

  assign strobe.capture = inValid;
  assign strobe.slot    = slotQ;

  // R5
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotQ == LAST_SLOT) |=> (slotQ == '0));

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotQ != LAST_SLOT) |=> (slotQ == $past(slotQ) + 1'b1));

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotQ <= LAST_SLOT);
endmodule

// File: rtl/ilv_unit.sv
module ilv_unit #(
  parameter int DATA_W = 16,
  parameter int RES_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              holdValid,
  output logic [RES_W-1:0]  result
);
  logic [DATA_W-1:0] aQ, bQ;
  logic              validQ;

  // Operands are captured only in this unit's slot and then held for a lap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      aQ     <= '0;
      bQ     <= '0;
    end else if (load) begin
      validQ <= inValid;
      if (inValid) begin
        aQ <= inA;
        bQ <= inB;
      end
    end
  end

  // Slow function; it has a whole lap of the slot counter to settle.
  assign result    = RES_W'(aQ) * RES_W'(bQ) + RES_W'(aQ ^ bQ);
  assign holdValid = validQ;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(aQ) && $stable(bQ) && $stable(validQ)));
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath #(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 16,
  parameter int RES_W     = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ilv_pkg::ilvStrobe_t strobe,
  input  logic [DATA_W-1:0]   inA,
  input  logic [DATA_W-1:0]   inB,
  output logic                outValid,
  output logic [RES_W-1:0]    outResult
);
  import ilv_pkg::*;

  logic [NUM_UNITS-1:0] loadVec;
  logic [NUM_UNITS-1:0] unitValid;
  logic [RES_W-1:0]     unitRes [NUM_UNITS];

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnit
    assign loadVec[g] = (strobe.slot == SLOT_W'(g));

    ilv_unit #(
      .DATA_W(DATA_W),
      .RES_W (RES_W)
    ) uUnit (
      .clk      (clk),
      .rstN     (rstN),
      .load     (loadVec[g]),
      .inValid  (strobe.capture),
      .inA      (inA),
      .inB      (inB),
      .holdValid(unitValid[g]),
      .result   (unitRes[g])
    );
  end

  // Output mux steered by the same slot that steers capture.
  always_comb begin
    outValid  = 1'b0;
    outResult = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (strobe.slot == SLOT_W'(i)) begin
        outValid  = unitValid[i];
        outResult = unitRes[i];
      end
    end
  end

  // R4
  one_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(loadVec) == 1);
endmodule

// File: rtl/interleave_array.sv
module interleave_array #(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 16,
  parameter int RES_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [RES_W-1:0]  outResult
);
  import ilv_pkg::*;

  ilvStrobe_t strobe;

  ilv_ctrl #(
    .NUM_UNITS(NUM_UNITS)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobe (strobe)
  );

  ilv_datapath #(
    .NUM_UNITS(NUM_UNITS),
    .DATA_W   (DATA_W),
    .RES_W    (RES_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inA      (inA),
    .inB      (inB),
    .outValid (outValid),
    .outResult(outResult)
  );

  // Shadow record of inValid, used only by the checks below.
  logic [NUM_UNITS-1:0] validHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validHist <= '0;
    end else begin
      validHist <= {validHist[NUM_UNITS-2:0], inValid};
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == validHist[NUM_UNITS-1]);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validHist == '0) |-> !outValid);
endmodule

// File: tb/tb_interleave_array.sv
module tb_interleave_array;
  localparam int N    = 4;
  localparam int DW   = 16;
  localparam int RW   = 2 * DW;
  localparam int HMAX = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inA = '0;
  logic [DW-1:0] inB = '0;
  logic          outValid;
  logic [RW-1:0] outResult;

  interleave_array #(.NUM_UNITS(N), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inA(inA), .inB(inB),
    .outValid(outValid), .outResult(outResult)
  );

  always #2 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  int stepIdx = 0;
  bit done = 1'b0;
  logic          histV [HMAX];
  logic [RW-1:0] histR [HMAX];

  function automatic logic [RW-1:0] model(logic [DW-1:0] a, logic [DW-1:0] b);
    return RW'(a) * RW'(b) + RW'(a ^ b);
  endfunction

  task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s step %0d: actual %h expected %h", req, stepIdx, act, exp);
    end
  endtask

  // One clock: check what the output shows, then drive the next pair.
  task automatic step(logic v, logic [DW-1:0] a, logic [DW-1:0] b,
                      string resReq, string vReq);
    @(negedge clk);
    if (stepIdx >= N) begin
      check(vReq, RW'(outValid), RW'(histV[(stepIdx - N) % HMAX]));
      if (histV[(stepIdx - N) % HMAX])
        check(resReq, outResult, histR[(stepIdx - N) % HMAX]);
    end else begin
      check(vReq, RW'(outValid), '0);
    end
    inValid = v;
    inA = a;
    inB = b;
    histV[stepIdx % HMAX] = v;
    histR[stepIdx % HMAX] = model(a, b);
    stepIdx++;
  endtask

  task automatic doReset(string req);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    check(req, RW'(outValid), '0);
    @(negedge clk);
    check(req, RW'(outValid), '0);
    rstN = 1'b1;
    histV[0] = 1'b0;
    histR[0] = '0;
    stepIdx = 1;
  endtask

  task automatic testReset();
    doReset("R1");
    for (int i = 0; i < N + 2; i++) step(1'b0, '0, '0, "R1", "R1");
  endtask

  task automatic testFullRate();
    for (int i = 0; i < 40; i++)
      step(1'b1, DW'($urandom), DW'($urandom), "R3", "R4");
    for (int i = 0; i < N; i++) step(1'b0, '0, '0, "R4", "R2");
  endtask

  task automatic testExtremes();
    step(1'b1, '1, '1, "R3", "R2");
    step(1'b1, '0, '1, "R3", "R2");
    step(1'b1, '1, '0, "R3", "R2");
    step(1'b1, '0, '0, "R3", "R2");
    step(1'b1, 16'h8000, 16'h8001, "R3", "R2");
    for (int i = 0; i < N; i++) step(1'b0, '0, '0, "R3", "R2");
  endtask

  task automatic testBubbles();
    for (int i = 0; i < 48; i++)
      step(1'($urandom), DW'($urandom), DW'($urandom), "R5", "R5");
    for (int i = 0; i < N; i++) step(1'b0, '0, '0, "R5", "R5");
  endtask

  task automatic testSkipSlot();
    for (int i = 0; i < 32; i++)
      step((stepIdx % N) != 2, DW'($urandom), DW'($urandom), "R6", "R5");
    for (int i = 0; i < N; i++) step(1'b0, '0, '0, "R6", "R5");
  endtask

  task automatic testOrder();
    for (int i = 0; i < 24; i++)
      step((i % 5) != 3, DW'(i + 1), DW'(3), "R7", "R7");
    for (int i = 0; i < N; i++) step(1'b0, '0, '0, "R7", "R7");
  endtask

  task automatic testMidReset();
    for (int i = 0; i < N + 2; i++)
      step(1'b1, DW'($urandom), DW'($urandom), "R3", "R2");
    doReset("R8");
    for (int i = 0; i < N + 2; i++) step(1'b0, '0, '0, "R8", "R8");
  endtask

  initial begin
    testReset();
    testFullRate();
    testExtremes();
    testBubbles();
    testSkipSlot();
    testOrder();
    testMidReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule